// File: doc/BRIEF.md
# Persistent Source and Destination Command Decoder

This block sits on the command path of a content-addressable memory device. It decodes 16-bit command words and decides three things: where later data reads are taken from, where later data writes land, and, for exactly one command cycle, which internal register a command read or write reaches instead of the status and instruction path. A chosen source or destination stays in force until another selection of the same kind or a reset. Choosing the memory array also steers an address pointer, which moves by one after each memory data access. The step direction comes from a control input.

Command words arrive on `dq_in[15:0]` with `cmd_wr`. When a memory selection carries the address flag (bit 11), the new pointer value comes from `dq_in[16+AW-1:16]` in the same cycle. Data cycles (`data_rd`, `data_wr`) use the selections that were in force before the clock edge. Memory accesses appear on the memory strobes together with the pointer value, the selected mask and the validity code. The array itself lives outside the block.

The one-shot redirection is a three-state machine. IDLE is the normal state: command reads return status and command writes are decoded. In IDLE, a valid override word with the flag set moves to OVR_WRITE, and one with the flag clear moves to OVR_READ. From OVR_WRITE, the next command write returns to IDLE. From OVR_READ, the next command read returns to IDLE, unless a new override word arrives in that same cycle. In that case the new override replaces the old one.

Top module: `cam_sel_decoder`

## Requirements
- R1: After reset the source and destination selections are comparand (code 000), mask select is 00, validity is 000, the pointer is 0 and the machine is IDLE. A command read in IDLE or OVR_WRITE returns `status_in` on all 32 bits. `rd_data` is 0 when no read strobe is high.
- R2: In IDLE or OVR_READ, a command write whose bits 15:12 are 0, bits 10:8 are 000 and bits 7:3 are 0 selects the data-read source from bits 2:0. The legal source codes are 000 comparand, 001 mask one, 010 mask two and 100 memory. The source persists until the next such word.
- R3: A command word with bits 15:12 = 0 and bits 10:8 = 001 sets the destination from bits 5:3 (same codes as R2), the mask select from bits 7:6 and the validity code from bits 2:0. These values persist and appear on `dst_sel`, `mask_sel` and `valid_sel`.
- R4: The block ignores, and leaves every selection unchanged for, a word with nonzero bits 15:12, any other opcode, a source or destination code of 011, 101, 110 or 111, nonzero bits 7:3 in a source word, or nonzero bits 7:6 or 2:0 in an override word.
- R5: Selecting memory with bit 11 set loads the pointer from `dq_in[16+AW-1:16]`. With bit 11 clear, the pointer keeps its value.
- R6: A data read with the memory source, or a data write with the memory destination, raises `mem_rd` or `mem_wr` at the current pointer. The pointer then moves by one, up when `ar_dir` is 0 and down when it is 1, wrapping modulo 2^AW.
- R7: A data read returns the selected source register zero-extended, or `mem_rdata` zero-extended when the source is memory.
- R8: Mask select 01 picks mask one and 10 picks mask two; 00 and 11 pick no mask. A data write to the comparand keeps the bits where the picked mask is 1. Data writes to mask one or mask two replace them whole. A memory write drives `mem_wdata` = `dq_in[15:0]` and `mem_wmask` = picked mask.
- R9: An override word (bits 15:12 = 0, bits 10:8 = 010) with bit 11 set makes the next command write store `dq_in[15:0]` into the register coded in bits 5:3. Register codes: 000 comparand, 001 mask one, 010 mask two, 011 pointer, 100 page address, 101 status view, 110 source view (`{13'b0,src}`), 111 destination view (`{8'b0,mask,dst,validity}`). That command write is not decoded.
- R10: An override word with bit 11 clear makes the next command read return `{status_in[31:16], register}`, except that reading the page address gives zeros in bits 31:16.
- R11: An override covers one access only. Command reads during OVR_WRITE return status and leave it pending. Command writes during OVR_READ are decoded normally.
- R12: An override write to codes 101, 110 or 111 changes nothing but still ends the override.
- R13: When a command-side write or pointer load and a data-side write or step fall in the same cycle, the command side wins. The data access itself uses the selections and pointer from before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_rd | input | 1 | Command read strobe |
| data_wr | input | 1 | Data write strobe |
| data_rd | input | 1 | Data read strobe |
| dq_in | input | 2*DW | Command word, data and address field |
| ar_dir | input | 1 | Pointer step direction, 1 = down |
| status_in | input | 2*DW | Status word from the array side |
| mem_rdata | input | DW | Read data from the memory array |
| rd_data | output | 2*DW | Read result for command or data reads |
| src_sel | output | 3 | Persistent source code |
| dst_sel | output | 3 | Persistent destination code |
| mask_sel | output | 2 | Persistent mask select |
| valid_sel | output | 3 | Validity code for memory writes |
| ar_value | output | AW | Address pointer |
| mem_rd | output | 1 | Memory read access |
| mem_wr | output | 1 | Memory write access |
| mem_wdata | output | DW | Memory write data |
| mem_wmask | output | DW | Memory write mask |

## Verification
A command write and a data access can share a cycle. The interesting cases are a memory selection with an explicit address landing in the same cycle as a memory data read, and an override write to the comparand coinciding with a masked data write to it. Directed cycles raise both strobes at once. The bench then judges that the data read returned the old pointer's data, that the pointer took the loaded value rather than the stepped one, and that an override read of the comparand shows the command-side value. Seeded random cycles then raise all four strobes freely against a bench model that applies data-side effects first and lets command-side effects overwrite them.

// File: rtl/cam_sel_pkg.sv
package cam_sel_pkg;

    typedef enum logic [1:0] {
        OVR_IDLE  = 2'd0,
        OVR_WRITE = 2'd1,
        OVR_READ  = 2'd2
    } ovr_state_e;

    localparam logic [2:0] SEL_CMP  = 3'd0;
    localparam logic [2:0] SEL_MSK1 = 3'd1;
    localparam logic [2:0] SEL_MSK2 = 3'd2;
    localparam logic [2:0] SEL_MEM  = 3'd4;

    localparam logic [2:0] REG_CMP  = 3'd0;
    localparam logic [2:0] REG_MSK1 = 3'd1;
    localparam logic [2:0] REG_MSK2 = 3'd2;
    localparam logic [2:0] REG_AR   = 3'd3;
    localparam logic [2:0] REG_PAGE = 3'd4;
    localparam logic [2:0] REG_STAT = 3'd5;
    localparam logic [2:0] REG_PSRC = 3'd6;
    localparam logic [2:0] REG_PDST = 3'd7;

    localparam logic [2:0] OP_SRC = 3'd0;
    localparam logic [2:0] OP_DST = 3'd1;
    localparam logic [2:0] OP_OVR = 3'd2;

    typedef struct packed {
        logic       src_ok;
        logic       dst_ok;
        logic       ovr_ok;
        logic       flag;
        logic [1:0] mm;
        logic [2:0] sel;
        logic [2:0] vvv;
    } cmd_dec_t;

    function automatic logic sel_legal(input logic [2:0] s);
        return (s == SEL_CMP) || (s == SEL_MSK1) || (s == SEL_MSK2) || (s == SEL_MEM);
    endfunction

endpackage

// File: rtl/cam_cmd_decode.sv
module cam_cmd_decode
    import cam_sel_pkg::*;
(
    input  logic [15:0] word,
    output cmd_dec_t    dec
);

    always_comb begin
        dec      = '0;
        dec.flag = word[11];
        if (word[15:12] == 4'h0) begin
            unique case (word[10:8])
                OP_SRC: begin
                    if (word[7:3] == 5'd0 && sel_legal(word[2:0])) begin
                        dec.src_ok = 1'b1;
                        dec.sel    = word[2:0];
                    end
                end
                OP_DST: begin
                    if (sel_legal(word[5:3])) begin
                        dec.dst_ok = 1'b1;
                        dec.mm     = word[7:6];
                        dec.sel    = word[5:3];
                        dec.vvv    = word[2:0];
                    end
                end
                OP_OVR: begin
                    if (word[7:6] == 2'd0 && word[2:0] == 3'd0) begin
                        dec.ovr_ok = 1'b1;
                        dec.sel    = word[5:3];
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cam_ovr_fsm.sv
module cam_ovr_fsm
    import cam_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       cmd_rd,
    input  logic       ovr_ok,
    input  logic       ovr_flag,
    input  logic [2:0] ovr_code,
    output ovr_state_e state,
    output logic [2:0] reg_sel,
    output logic       decode_en,
    output logic       wr_fire,
    output logic       rd_active
);

    ovr_state_e state_nxt;
    logic [2:0] reg_nxt;

    always_comb begin
        state_nxt = state;
        reg_nxt   = reg_sel;
        unique case (state)
            OVR_IDLE: begin
                if (cmd_wr && ovr_ok) begin
                    state_nxt = ovr_flag ? OVR_WRITE : OVR_READ;
                    reg_nxt   = ovr_code;
                end
            end
            OVR_WRITE: begin
                if (cmd_wr) state_nxt = OVR_IDLE;
            end
            OVR_READ: begin
                if (cmd_wr && ovr_ok) begin
                    state_nxt = ovr_flag ? OVR_WRITE : OVR_READ;
                    reg_nxt   = ovr_code;
                end else if (cmd_rd) begin
                    state_nxt = OVR_IDLE;
                end
            end
            default: state_nxt = OVR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= OVR_IDLE;
            reg_sel <= REG_CMP;
        end else begin
            state   <= state_nxt;
            reg_sel <= reg_nxt;
        end
    end

    always_comb begin
        decode_en = (state != OVR_WRITE);
        wr_fire   = (state == OVR_WRITE) && cmd_wr;
        rd_active = (state == OVR_READ);
    end

endmodule

// File: rtl/cam_addr_ptr.sv
module cam_addr_ptr #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          dir_down,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= '0;
        else if (load)     ptr <= load_val;
        else if (step)     ptr <= dir_down ? ptr - ONE : ptr + ONE;
    end

endmodule

// File: rtl/cam_sel_decoder.sv
module cam_sel_decoder
    import cam_sel_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [2*DW-1:0]   dq_in,
    input  logic              ar_dir,
    input  logic [2*DW-1:0]   status_in,
    input  logic [DW-1:0]     mem_rdata,
    output logic [2*DW-1:0]   rd_data,
    output logic [2:0]        src_sel,
    output logic [2:0]        dst_sel,
    output logic [1:0]        mask_sel,
    output logic [2:0]        valid_sel,
    output logic [AW-1:0]     ar_value,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW-1:0]     mem_wmask
);

    localparam int BW = 2 * DW;
    localparam int IW = 16;

    cmd_dec_t   dec;
    ovr_state_e ovr_state;
    logic [2:0] ovr_reg;
    logic       decode_en, ovr_wr_fire, ovr_rd_active;
    logic       src_fire, dst_fire, ptr_load, ptr_step;
    logic [AW-1:0] ptr_val;
    logic [DW-1:0] wdata, pick_mask, reg_view, src_view;
    logic [DW-1:0] cmp_q, msk1_q, msk2_q, page_q;
    logic [2:0] src_q, dst_q, vvv_q;
    logic [1:0] mm_q;
    logic       unused_hi;

    assign unused_hi = ^dq_in[BW-1:DW+AW];

    cam_cmd_decode u_decode (
        .word (dq_in[IW-1:0]),
        .dec  (dec)
    );

    cam_ovr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_rd    (cmd_rd),
        .ovr_ok    (dec.ovr_ok),
        .ovr_flag  (dec.flag),
        .ovr_code  (dec.sel),
        .state     (ovr_state),
        .reg_sel   (ovr_reg),
        .decode_en (decode_en),
        .wr_fire   (ovr_wr_fire),
        .rd_active (ovr_rd_active)
    );

    assign wdata    = dq_in[DW-1:0];
    assign src_fire = cmd_wr && decode_en && dec.src_ok;
    assign dst_fire = cmd_wr && decode_en && dec.dst_ok;

    always_comb begin
        ptr_load = 1'b0;
        ptr_val  = dq_in[DW +: AW];
        if (ovr_wr_fire && ovr_reg == REG_AR) begin
            ptr_load = 1'b1;
            ptr_val  = wdata[AW-1:0];
        end else if ((src_fire || dst_fire) && dec.sel == SEL_MEM && dec.flag) begin
            ptr_load = 1'b1;
        end
        ptr_step = (data_rd && src_q == SEL_MEM) || (data_wr && dst_q == SEL_MEM);
    end

    cam_addr_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_val),
        .step     (ptr_step),
        .dir_down (ar_dir),
        .ptr      (ar_value)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SEL_CMP;
            dst_q <= SEL_CMP;
            mm_q  <= 2'd0;
            vvv_q <= 3'd0;
        end else begin
            if (src_fire) src_q <= dec.sel;
            if (dst_fire) begin
                dst_q <= dec.sel;
                mm_q  <= dec.mm;
                vvv_q <= dec.vvv;
            end
        end
    end

    always_comb begin
        unique case (mm_q)
            2'b01:   pick_mask = msk1_q;
            2'b10:   pick_mask = msk2_q;
            default: pick_mask = '0;
        endcase
    end

    // Data-side writes first; command-side writes later in the block win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            msk1_q <= '0;
            msk2_q <= '0;
            page_q <= '0;
        end else begin
            if (data_wr) begin
                unique case (dst_q)
                    SEL_CMP:  cmp_q  <= (cmp_q & pick_mask) | (wdata & ~pick_mask);
                    SEL_MSK1: msk1_q <= wdata;
                    SEL_MSK2: msk2_q <= wdata;
                    default:  ;
                endcase
            end
            if (ovr_wr_fire) begin
                unique case (ovr_reg)
                    REG_CMP:  cmp_q  <= wdata;
                    REG_MSK1: msk1_q <= wdata;
                    REG_MSK2: msk2_q <= wdata;
                    REG_PAGE: page_q <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (ovr_reg)
            REG_CMP:  reg_view = cmp_q;
            REG_MSK1: reg_view = msk1_q;
            REG_MSK2: reg_view = msk2_q;
            REG_AR:   reg_view = {{(DW-AW){1'b0}}, ar_value};
            REG_PAGE: reg_view = page_q;
            REG_STAT: reg_view = status_in[DW-1:0];
            REG_PSRC: reg_view = {{(DW-3){1'b0}}, src_q};
            default:  reg_view = {{(DW-8){1'b0}}, mm_q, dst_q, vvv_q};
        endcase
    end

    always_comb begin
        unique case (src_q)
            SEL_MSK1: src_view = msk1_q;
            SEL_MSK2: src_view = msk2_q;
            SEL_MEM:  src_view = mem_rdata;
            default:  src_view = cmp_q;
        endcase
    end

    always_comb begin
        rd_data = '0;
        if (cmd_rd) begin
            if (!ovr_rd_active)            rd_data = status_in;
            else if (ovr_reg == REG_PAGE)  rd_data = {{DW{1'b0}}, page_q};
            else                           rd_data = {status_in[BW-1:DW], reg_view};
        end else if (data_rd) begin
            rd_data = {{DW{1'b0}}, src_view};
        end
    end

    assign src_sel   = src_q;
    assign dst_sel   = dst_q;
    assign mask_sel  = mm_q;
    assign valid_sel = vvv_q;
    assign mem_rd    = data_rd && src_q == SEL_MEM;
    assign mem_wr    = data_wr && dst_q == SEL_MEM;
    assign mem_wdata = wdata;
    assign mem_wmask = pick_mask;

endmodule

// File: rtl/cam_sel_decoder_chk.sv
module cam_sel_decoder_chk #(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_wr,
    input logic            cmd_rd,
    input logic            ar_dir,
    input logic [2*DW-1:0] status_in,
    input logic [2*DW-1:0] rd_data,
    input logic [2:0]      src_sel,
    input logic [2:0]      dst_sel,
    input logic [AW-1:0]   ar_value,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic [1:0]      ovr_state,
    input logic [2:0]      ovr_reg
);

    p_status_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && ovr_state != 2'd2) |-> rd_data == status_in)
        else $error("status read");

    p_src_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(src_sel))
        else $error("source moved");

    p_dst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(dst_sel))
        else $error("destination moved");

    p_ptr_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !cmd_wr && !ar_dir) |=> ar_value == AW'($past(ar_value) + 1'b1))
        else $error("pointer step");

    p_page_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && ovr_state == 2'd2 && ovr_reg == 3'd4) |-> rd_data[2*DW-1:DW] == '0)
        else $error("page upper half");

    p_wr_oneshot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_state == 2'd1 && cmd_wr) |=> ovr_state == 2'd0)
        else $error("write override kept");

    p_rd_oneshot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_state == 2'd2 && cmd_rd && !cmd_wr) |=> ovr_state == 2'd0)
        else $error("read override kept");

endmodule

bind cam_sel_decoder cam_sel_decoder_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_rd    (cmd_rd),
    .ar_dir    (ar_dir),
    .status_in (status_in),
    .rd_data   (rd_data),
    .src_sel   (src_sel),
    .dst_sel   (dst_sel),
    .ar_value  (ar_value),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .ovr_state (ovr_state),
    .ovr_reg   (ovr_reg)
);

// File: tb/cam_sel_decoder_tb.sv
module cam_sel_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 12;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          rst_n, cmd_wr, cmd_rd, data_wr, data_rd, ar_dir;
    logic [31:0]   dq_in, status_in, rd_data;
    logic [15:0]   mem_rdata, mem_wdata, mem_wmask;
    logic [2:0]    src_sel, dst_sel, valid_sel;
    logic [1:0]    mask_sel;
    logic [AW-1:0] ar_value;
    logic          mem_rd, mem_wr;

    cam_sel_decoder #(.DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
        .data_wr(data_wr), .data_rd(data_rd), .dq_in(dq_in), .ar_dir(ar_dir),
        .status_in(status_in), .mem_rdata(mem_rdata), .rd_data(rd_data),
        .src_sel(src_sel), .dst_sel(dst_sel), .mask_sel(mask_sel),
        .valid_sel(valid_sel), .ar_value(ar_value), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string tag   = "R1";

    logic [2:0]    m_src, m_dst, m_vvv, m_reg;
    logic [1:0]    m_mm, m_ovr;
    logic [AW-1:0] m_ar;
    logic [15:0]   m_cmp, m_m1, m_m2, m_pg;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] w_src(input logic f, input logic [2:0] s);
        return {4'h0, f, 3'b000, 5'b00000, s};
    endfunction
    function automatic logic [15:0] w_dst(input logic f, input logic [1:0] mm,
                                          input logic [2:0] d, input logic [2:0] v);
        return {4'h0, f, 3'b001, mm, d, v};
    endfunction
    function automatic logic [15:0] w_ovr(input logic f, input logic [2:0] r);
        return {4'h0, f, 3'b010, 2'b00, r, 3'b000};
    endfunction
    function automatic logic legal(input logic [2:0] s);
        return s == 3'd0 || s == 3'd1 || s == 3'd2 || s == 3'd4;
    endfunction
    function automatic logic [15:0] mask_of(input logic [1:0] mm);
        return (mm == 2'b01) ? m_m1 : (mm == 2'b10) ? m_m2 : 16'h0;
    endfunction
    function automatic logic [15:0] view(input logic [2:0] c, input logic [31:0] st);
        case (c)
            3'd0: return m_cmp;
            3'd1: return m_m1;
            3'd2: return m_m2;
            3'd3: return {4'h0, m_ar};
            3'd4: return m_pg;
            3'd5: return st[15:0];
            3'd6: return {13'h0, m_src};
            default: return {8'h0, m_mm, m_dst, m_vvv};
        endcase
    endfunction

    task automatic model_reset();
        m_src = 0; m_dst = 0; m_vvv = 0; m_reg = 0; m_mm = 0; m_ovr = 0;
        m_ar = 0; m_cmp = 0; m_m1 = 0; m_m2 = 0; m_pg = 0;
    endtask

    task automatic cyc(input logic cw, input logic cr, input logic dw, input logic dr,
                       input logic [31:0] dq, input logic dir,
                       input logic [31:0] st, input logic [15:0] mrd);
        logic [31:0] e_rd;
        logic [15:0] d, mk;
        logic        new_ovr;
        @(negedge clk);
        cmd_wr = cw; cmd_rd = cr; data_wr = dw; data_rd = dr;
        dq_in = dq; ar_dir = dir; status_in = st; mem_rdata = mrd;
        #1;
        d  = dq[15:0];
        mk = mask_of(m_mm);
        if (cr) begin
            if (m_ovr == 2'd2) e_rd = (m_reg == 3'd4) ? {16'h0, m_pg} : {st[31:16], view(m_reg, st)};
            else               e_rd = st;
        end else if (dr) begin
            e_rd = {16'h0, (m_src == 3'd4) ? mrd : view(m_src, st)};
        end else begin
            e_rd = 32'h0;
        end
        chk("rd_data", rd_data, e_rd);
        chk("R2 src_sel", {29'h0, src_sel}, {29'h0, m_src});
        chk("R3 dst_sel", {29'h0, dst_sel}, {29'h0, m_dst});
        chk("R3 mask/valid", {27'h0, mask_sel, valid_sel}, {27'h0, m_mm, m_vvv});
        chk("R6 ar_value", {20'h0, ar_value}, {20'h0, m_ar});
        chk("R6 mem_rd", {31'h0, mem_rd}, {31'h0, dr && m_src == 3'd4});
        chk("R6 mem_wr", {31'h0, mem_wr}, {31'h0, dw && m_dst == 3'd4});
        if (dw && m_dst == 3'd4)
            chk("R8 mem_wdata/wmask", {mem_wdata, mem_wmask}, {d, mk});
        // data side with pre-edge state
        if (dw) begin
            case (m_dst)
                3'd0: m_cmp = (m_cmp & mk) | (d & ~mk);
                3'd1: m_m1 = d;
                3'd2: m_m2 = d;
                default: ;
            endcase
        end
        if ((dr && m_src == 3'd4) || (dw && m_dst == 3'd4))
            m_ar = dir ? m_ar - 1'b1 : m_ar + 1'b1;
        // command side wins
        new_ovr = 1'b0;
        if (cw && m_ovr == 2'd1) begin
            case (m_reg)
                3'd0: m_cmp = d;
                3'd1: m_m1 = d;
                3'd2: m_m2 = d;
                3'd3: m_ar = d[AW-1:0];
                3'd4: m_pg = d;
                default: ;
            endcase
            m_ovr = 2'd0;
        end else begin
            if (cw && d[15:12] == 4'h0) begin
                case (d[10:8])
                    3'd0: if (d[7:3] == 5'd0 && legal(d[2:0])) begin
                        m_src = d[2:0];
                        if (d[2:0] == 3'd4 && d[11]) m_ar = dq[16 +: AW];
                    end
                    3'd1: if (legal(d[5:3])) begin
                        m_mm = d[7:6]; m_dst = d[5:3]; m_vvv = d[2:0];
                        if (d[5:3] == 3'd4 && d[11]) m_ar = dq[16 +: AW];
                    end
                    3'd2: if (d[7:6] == 2'd0 && d[2:0] == 3'd0) begin
                        m_ovr = d[11] ? 2'd1 : 2'd2; m_reg = d[5:3]; new_ovr = 1'b1;
                    end
                    default: ;
                endcase
            end
            if (!new_ovr && m_ovr == 2'd2 && cr) m_ovr = 2'd0;
        end
    endtask

    task automatic cwr(input logic [31:0] dq);
        cyc(1, 0, 0, 0, dq, 0, 32'hC0DE_0000, 16'h0);
    endtask
    task automatic crd(input logic [31:0] st);
        cyc(0, 1, 0, 0, 32'h0, 0, st, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL R13 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; cmd_wr = 0; cmd_rd = 0; data_wr = 0; data_rd = 0;
        dq_in = 0; ar_dir = 0; status_in = 0; mem_rdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        tag = "R1";
        crd(32'h1234_5678);
        cyc(0, 0, 0, 0, 32'hFFFF_FFFF, 0, 32'h0, 16'h0);

        tag = "R9";
        cwr({16'h0, w_ovr(1, 3'd1)});
        cwr(32'h0000_A5A5);
        cwr({16'h0, w_ovr(1, 3'd0)});
        cwr(32'h0000_00FF);

        tag = "R2";
        cwr({16'h0, w_src(0, 3'd1)});
        cyc(0, 0, 0, 1, 32'h0, 0, 32'h0, 16'h0);
        cyc(0, 0, 0, 1, 32'h0, 0, 32'h0, 16'h0);

        tag = "R8";
        cwr({16'h0, w_dst(0, 2'b01, 3'd0, 3'd5)});
        cyc(0, 0, 1, 0, 32'h0000_1234, 0, 32'h0, 16'h0);
        cwr({16'h0, w_ovr(0, 3'd0)});
        crd(32'hAAAA_0000);
        cwr({16'h0, w_dst(0, 2'b11, 3'd2, 3'd0)});
        cyc(0, 0, 1, 0, 32'h0000_0F0F, 0, 32'h0, 16'h0);

        tag = "R4";
        cwr({16'h0, 16'h1004});
        cwr({16'h0, w_src(0, 3'd3)});
        cwr({16'h0, w_dst(1, 2'b01, 3'd5, 3'd1)});
        cwr({16'h0, 16'h0208});
        cwr({16'h0, 16'h0301});
        cwr({16'h0, 16'h0011});
        crd(32'h5555_AAAA);

        tag = "R5";
        cwr({16'h0123, w_src(1, 3'd4)});
        cwr({16'h0456, w_dst(0, 2'b10, 3'd4, 3'd3)});

        tag = "R6";
        cyc(0, 0, 0, 1, 32'h0, 0, 32'h0, 16'hBEEF);
        cyc(0, 0, 1, 0, 32'h0000_7777, 1, 32'h0, 16'h0);
        cwr({16'h0000, w_src(1, 3'd4)});
        cyc(0, 0, 0, 1, 32'h0, 1, 32'h0, 16'h1111);
        cyc(0, 0, 1, 1, 32'h0000_2222, 0, 32'h0, 16'h3333);

        tag = "R7";
        cyc(0, 0, 0, 1, 32'h0, 0, 32'h0, 16'hCAFE);

        tag = "R10";
        cwr({16'h0, w_ovr(1, 3'd4)});
        cwr(32'hFFFF_0042);
        cwr({16'h0, w_ovr(0, 3'd4)});
        crd(32'hDEAD_BEEF);
        cwr({16'h0, w_ovr(0, 3'd7)});
        crd(32'h9876_5432);

        tag = "R11";
        cwr({16'h0, w_ovr(0, 3'd1)});
        cwr({16'h0, w_src(0, 3'd2)});
        crd(32'h1111_2222);
        crd(32'h3333_4444);
        cwr({16'h0, w_ovr(1, 3'd2)});
        crd(32'h5555_6666);
        cwr(32'h0000_00F0);
        cyc(0, 0, 0, 1, 32'h0, 0, 32'h0, 16'h0);

        tag = "R12";
        cwr({16'h0, w_ovr(1, 3'd6)});
        cwr(32'h0000_0004);
        cwr({16'h0, w_ovr(1, 3'd5)});
        cwr({16'h0, w_src(0, 3'd0)});
        cwr({16'h0, w_ovr(0, 3'd6)});
        crd(32'h0);

        tag = "R13";
        cwr({16'h0010, w_src(1, 3'd4)});
        cyc(1, 0, 0, 1, {16'h0200, w_src(1, 3'd4)}, 0, 32'h0, 16'h4444);
        cwr({16'h0, w_dst(0, 2'b00, 3'd0, 3'd0)});
        cwr({16'h0, w_ovr(1, 3'd0)});
        cyc(1, 0, 1, 0, 32'h0000_8181, 0, 32'h0, 16'h0);
        cwr({16'h0, w_ovr(0, 3'd0)});
        crd(32'h0);

        for (int i = 0; i < 1500; i++) begin
            logic [15:0] w;
            logic [31:0] r;
            r = $urandom;
            case ($urandom % 5)
                0: w = w_src(r[0], r[3:1]);
                1: w = w_dst(r[0], r[2:1], r[5:3], r[8:6]);
                2: w = w_ovr(r[0], r[3:1]);
                3: w = {r[15:0]};
                default: w = w_src(r[0], 3'd4);
            endcase
            cyc(($urandom % 2) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
                ($urandom % 3) == 0, {r[31:16], w}, r[9], $urandom, r[15:0] ^ 16'h5A5A);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule